// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block derives the serial clock of an SPI master from a faster functional clock. The total divide ratio comes from two non-binary lookup encodings: a 2-bit prescaler code and a 4-bit scaler code. A double-rate bit can halve the product. While a frame is active the block toggles SCK. While no frame is active SCK rests at the level the polarity bit selects.

Alongside SCK the block gives the shift engine one-cycle strobes. One marks the leading edge, one marks the trailing edge, and a combined toggle strobe marks either. The shifter picks its sample and launch edges from these strobes according to its clock phase setting. The configuration is captured only while the generator is idle, so a frame always runs at the rate that was set up before it began.

Top module: `sck_baud_gen`

## Requirements
- R1: The prescaler code selects the factor P: code 0 gives 2, code 1 gives 3, code 2 gives 5 and code 3 gives 7.
- R2: The scaler code selects the factor S. Codes 0 to 3 give 2, 4, 6 and 8. Any code c from 4 to 15 gives 2 to the power c.
- R3: One SCK period lasts N functional-clock cycles. N is P*S when the double-rate bit is 0 and P*S/2 when it is 1. N is measured as the distance between consecutive leading-edge strobes.
- R4: The half-period that follows a leading edge lasts ceil(N/2) cycles. The half-period that follows a trailing edge lasts floor(N/2) cycles. For odd N the active phase is therefore one cycle longer.
- R5: After reset SCK is 0 and all strobes are low. While idle, SCK follows the polarity bit one cycle after it is set.
- R6: At the first clock edge that sees frame_active high while idle, the generator starts a new period at the idle level. Its first leading-edge strobe is high in the floor(N/2)-th cycle after that edge.
- R7: Changes to the prescaler, scaler, double-rate or polarity inputs made while a frame runs have no effect until the generator has gone idle and a new frame starts.
- R8: lead_edge and trail_edge are never high together, and sck_tick is high exactly when one of them is. SCK moves to the active level at the clock edge that ends a lead_edge cycle, and back to the idle level at the edge that ends a trail_edge cycle. While a frame runs, SCK is otherwise stable.
- R9: When frame_active is low, no strobe is produced in that cycle, and SCK is back at the idle level after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_active | input | 1 | High while a frame is being shifted |
| cfg_pre_sel | input | 2 | Prescaler code (factor 2/3/5/7) |
| cfg_scl_sel | input | 4 | Scaler code (factor 2..32768) |
| cfg_dbl | input | 1 | Double-rate: halves the total ratio |
| cfg_cpol | input | 1 | Idle level of SCK |
| sck | output | 1 | Serial clock |
| sck_tick | output | 1 | One-cycle strobe before any SCK toggle |
| lead_edge | output | 1 | One-cycle strobe before the leading SCK edge |
| trail_edge | output | 1 | One-cycle strobe before the trailing SCK edge |

## Verification
The hardest cases to reach are a configuration change in the middle of a frame and a frame that ends in the very cycle a strobe would fire. The stimulus waits for the first leading-edge strobe and then drives a new set of codes and the opposite polarity. It then measures the next trailing edge and the next period against the ratio that was captured before the change. For the early stop, frame_active is dropped in the cycle where the first leading strobe is due. Odd ratios come from the 3 and 7 prescalers combined with the double-rate bit. The largest scaler is run once with doubling so that the longest counter span is also covered.

// File: rtl/sck_gen_pkg.sv
package sck_gen_pkg;

  localparam int PRE_SEL_W = 2;
  localparam int SCL_SEL_W = 4;
  localparam int PRE_VAL_W = 3;
  localparam int SCL_VAL_W = 16;

  typedef struct packed {
    logic [PRE_SEL_W-1:0] pre;
    logic [SCL_SEL_W-1:0] scl;
    logic                 dbl;
    logic                 cpol;
  } sck_cfg_t;

  // prescaler factors are non-binary: 2, 3, 5, 7
  function automatic logic [PRE_VAL_W-1:0] pre_factor(input logic [PRE_SEL_W-1:0] code);
    logic [PRE_VAL_W-1:0] v;
    case (code)
      2'd0:    v = 3'd2;
      2'd1:    v = 3'd3;
      2'd2:    v = 3'd5;
      default: v = 3'd7;
    endcase
    return v;
  endfunction

  // low codes step linearly by two, upper codes are powers of two
  function automatic logic [SCL_VAL_W-1:0] scl_factor(input logic [SCL_SEL_W-1:0] code);
    logic [SCL_VAL_W-1:0] v;
    if (code < 4'd4) v = SCL_VAL_W'({code, 1'b0}) + SCL_VAL_W'(2);
    else             v = SCL_VAL_W'(1) << code;
    return v;
  endfunction

endpackage

// File: rtl/sck_cfg_hold.sv
module sck_cfg_hold
  import sck_gen_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  sck_cfg_t cfg_in,
  output sck_cfg_t cfg_q
);

  sck_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (load) cfg_d = cfg_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

endmodule

// File: rtl/sck_ratio_lut.sv
module sck_ratio_lut
  import sck_gen_pkg::*;
#(
  parameter int RATIO_W = 18
) (
  input  logic [PRE_SEL_W-1:0] pre_sel,
  input  logic [SCL_SEL_W-1:0] scl_sel,
  input  logic                 dbl,
  output logic [RATIO_W-1:0]   lo_len,
  output logic [RATIO_W-1:0]   hi_len
);

  logic [RATIO_W-1:0] pre_w;
  logic [RATIO_W-1:0] scl_w;
  logic [RATIO_W-1:0] product;
  logic [RATIO_W-1:0] total;

  always_comb begin
    pre_w   = RATIO_W'(pre_factor(pre_sel));
    scl_w   = RATIO_W'(scl_factor(scl_sel));
    product = pre_w * scl_w;
    // every scaler factor is even, so halving is exact
    total   = dbl ? (product >> 1) : product;
    lo_len  = total >> 1;
    hi_len  = total - lo_len;
  end

endmodule

// File: rtl/sck_phase_timer.sv
module sck_phase_timer #(
  parameter int HALF_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_active,
  input  logic [HALF_W-1:0] lo_len,
  input  logic [HALF_W-1:0] hi_len,
  input  logic              cpol,
  output logic              run,
  output logic              sck,
  output logic              tick,
  output logic              lead,
  output logic              trail
);

  logic              run_q, run_d;
  logic              act_q, act_d;
  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic [HALF_W-1:0] cur_len;
  logic              at_end;

  always_comb begin
    cur_len = act_q ? hi_len : lo_len;
    at_end  = run_q && frame_active && (cnt_q == cur_len - 1'b1);
    lead    = at_end && !act_q;
    trail   = at_end &&  act_q;
    tick    = at_end;
  end

  always_comb begin
    run_d = run_q;
    act_d = act_q;
    cnt_d = cnt_q;
    if (!frame_active) begin
      run_d = 1'b0;
      act_d = 1'b0;
      cnt_d = '0;
    end else if (!run_q) begin
      run_d = 1'b1;
      act_d = 1'b0;
      cnt_d = '0;
    end else if (at_end) begin
      act_d = !act_q;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign run = run_q;
  assign sck = cpol ^ act_q;

endmodule

// File: rtl/sck_baud_gen.sv
module sck_baud_gen
  import sck_gen_pkg::*;
#(
  parameter int RATIO_W = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_active,
  input  logic [1:0] cfg_pre_sel,
  input  logic [3:0] cfg_scl_sel,
  input  logic       cfg_dbl,
  input  logic       cfg_cpol,
  output logic       sck,
  output logic       sck_tick,
  output logic       lead_edge,
  output logic       trail_edge
);

  localparam int HALF_W = RATIO_W;

  sck_cfg_t          cfg_in;
  sck_cfg_t          cfg_q;
  logic              run;
  logic [HALF_W-1:0] lo_len;
  logic [HALF_W-1:0] hi_len;

  assign cfg_in = '{pre: cfg_pre_sel, scl: cfg_scl_sel, dbl: cfg_dbl, cpol: cfg_cpol};

  sck_cfg_hold i_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (!run),
    .cfg_in (cfg_in),
    .cfg_q  (cfg_q)
  );

  sck_ratio_lut #(.RATIO_W(RATIO_W)) i_lut (
    .pre_sel (cfg_q.pre),
    .scl_sel (cfg_q.scl),
    .dbl     (cfg_q.dbl),
    .lo_len  (lo_len),
    .hi_len  (hi_len)
  );

  sck_phase_timer #(.HALF_W(HALF_W)) i_tmr (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_active (frame_active),
    .lo_len       (lo_len),
    .hi_len       (hi_len),
    .cpol         (cfg_q.cpol),
    .run          (run),
    .sck          (sck),
    .tick         (sck_tick),
    .lead         (lead_edge),
    .trail        (trail_edge)
  );

endmodule

// File: rtl/sck_baud_gen_chk.sv
module sck_baud_gen_chk
  import sck_gen_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     frame_active,
  input logic     sck,
  input logic     sck_tick,
  input logic     lead_edge,
  input logic     trail_edge,
  input logic     run,
  input sck_cfg_t cfg_q
);

  // R8
  lead_trail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_edge && trail_edge));

  // R8
  lead_moves_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lead_edge |=> !$stable(sck));

  // R8
  trail_moves_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trail_edge |=> !$stable(sck));

  // R8
  quiet_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && frame_active && !sck_tick) |=> $stable(sck));

  // R9
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_active |-> !sck_tick);

  // R5
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_active |=> (sck == cfg_q.cpol));

  // R7
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(cfg_q));

endmodule

bind sck_baud_gen sck_baud_gen_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_active (frame_active),
  .sck          (sck),
  .sck_tick     (sck_tick),
  .lead_edge    (lead_edge),
  .trail_edge   (trail_edge),
  .run          (run),
  .cfg_q        (cfg_q)
);

// File: tb/test_sck_baud_gen.sv
module test_sck_baud_gen;

  logic       clk;
  logic       rst_n;
  logic       frame_active;
  logic [1:0] cfg_pre_sel;
  logic [3:0] cfg_scl_sel;
  logic       cfg_dbl;
  logic       cfg_cpol;
  logic       sck;
  logic       sck_tick;
  logic       lead_edge;
  logic       trail_edge;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;

  // reference model state
  int m_run  = 0;
  int m_pos  = 0;
  int m_pre  = 0;
  int m_scl  = 0;
  int m_dbl  = 0;
  int m_cpol = 0;

  sck_baud_gen i_sck_baud_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_active (frame_active),
    .cfg_pre_sel  (cfg_pre_sel),
    .cfg_scl_sel  (cfg_scl_sel),
    .cfg_dbl      (cfg_dbl),
    .cfg_cpol     (cfg_cpol),
    .sck          (sck),
    .sck_tick     (sck_tick),
    .lead_edge    (lead_edge),
    .trail_edge   (trail_edge)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int ratio_of(input int pre, input int scl, input int dbl);
    int pv[4] = '{2, 3, 5, 7};
    int s;
    int n;
    if (scl < 4) s = 2 * (scl + 1);
    else begin
      s = 1;
      for (int k = 0; k < scl; k++) s = s * 2;
    end
    n = pv[pre] * s;
    if (dbl != 0) n = n / 2;
    return n;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // model update on each active edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_pos = 0; m_pre = 0; m_scl = 0; m_dbl = 0; m_cpol = 0;
    end else begin
      int was_run;
      was_run = m_run;
      if (was_run == 0) begin
        m_pre = cfg_pre_sel; m_scl = cfg_scl_sel; m_dbl = cfg_dbl; m_cpol = cfg_cpol;
      end
      if (!frame_active) begin
        m_run = 0; m_pos = 0;
      end else if (was_run == 0) begin
        m_run = 1; m_pos = 0;
      end else begin
        m_pos = (m_pos + 1) % ratio_of(m_pre, m_scl, m_dbl);
      end
    end
  end

  // compare on every cycle, away from the edge
  always @(negedge clk) begin
    #2;
    begin
      int n, lo, e_sck, e_lead, e_trail;
      n  = ratio_of(m_pre, m_scl, m_dbl);
      lo = n / 2;
      e_sck   = m_cpol ^ ((m_run != 0 && m_pos >= lo) ? 1 : 0);
      e_lead  = (m_run != 0 && frame_active && m_pos == lo - 1) ? 1 : 0;
      e_trail = (m_run != 0 && frame_active && m_pos == n - 1) ? 1 : 0;
      check(sck == e_sck[0], "R8 sck level", sck, e_sck);
      check(lead_edge == e_lead[0], "R6 lead_edge", lead_edge, e_lead);
      check(trail_edge == e_trail[0], "R4 trail_edge", trail_edge, e_trail);
      check(sck_tick == (e_lead[0] | e_trail[0]), "R8 sck_tick", sck_tick, e_lead | e_trail);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 190000);
      summary();
    end
  end

  task automatic set_cfg(input int pre, input int scl, input int dbl, input int cpol);
    cfg_pre_sel = 2'(pre);
    cfg_scl_sel = 4'(scl);
    cfg_dbl     = 1'(dbl);
    cfg_cpol    = 1'(cpol);
  endtask

  // runs one frame and measures the strobe spacing in cycles
  task automatic frame(input int pre, input int scl, input int dbl, input int cpol,
                       input bit mid_change, input string tag);
    int n, lo, hi, idx, first, second, trail;
    bit changed;
    n  = ratio_of(pre, scl, dbl);
    lo = n / 2;
    hi = n - lo;
    @(negedge clk);
    frame_active = 1'b0;
    set_cfg(pre, scl, dbl, cpol);
    repeat (2) @(negedge clk);
    frame_active = 1'b1;
    idx = -1; first = -1; second = -1; trail = -1; changed = 1'b0;
    while (second < 0) begin
      @(negedge clk);
      if (mid_change && first >= 0 && !changed) begin
        set_cfg(3 - pre, 3, 1 - dbl, 1 - cpol);
        changed = 1'b1;
      end
      #3;
      idx++;
      if (lead_edge) begin
        if (first < 0) first = idx;
        else second = idx;
      end
      if (trail_edge && first >= 0 && trail < 0) trail = idx;
    end
    // R6: first leading strobe after floor(N/2) cycles
    check(first == lo - 1, "R6 first lead cycle", first, lo - 1);
    // R4: active half-period is ceil(N/2)
    check(trail - first == hi, "R4 active half", trail - first, hi);
    check(second - first == n, tag, second - first, n);
    @(negedge clk);
    frame_active = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    frame_active = 1'b0;
    set_cfg(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R5: reset state
    check(sck == 1'b0 && !sck_tick && !lead_edge && !trail_edge, "R5 reset outputs",
          {sck, sck_tick, lead_edge, trail_edge}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: every prescaler code
    for (int p = 0; p < 4; p++) frame(p, 0, 0, 0, 1'b0, "R1 period by prescaler");
    // R2: scaler codes, linear and power-of-two parts
    for (int s = 0; s < 12; s++) frame(0, s, 0, 0, 1'b0, "R2 period by scaler");
    frame(0, 15, 1, 0, 1'b0, "R2 largest scaler");
    // R3: double-rate halves the ratio
    frame(0, 2, 1, 0, 1'b0, "R3 double rate");
    frame(2, 4, 1, 0, 1'b0, "R3 double rate");
    // R4: odd totals
    frame(1, 0, 1, 0, 1'b0, "R4 odd ratio 3");
    frame(3, 2, 1, 0, 1'b0, "R4 odd ratio 21");

    // R5: idle level follows polarity
    @(negedge clk);
    set_cfg(0, 0, 0, 1);
    repeat (2) @(negedge clk);
    #3;
    check(sck == 1'b1, "R5 idle high", sck, 1);
    frame(1, 1, 0, 1, 1'b0, "R5 period with high idle");

    // R7: mid-frame change ignored
    frame(2, 1, 0, 0, 1'b1, "R7 ratio kept after mid-frame change");
    @(negedge clk);
    #3;
    check(sck == 1'b1, "R7 new polarity after frame", sck, 1);

    // R9: drop frame in the cycle a strobe is due (N=4, lead due at idx 1)
    @(negedge clk);
    set_cfg(0, 0, 0, 0);
    repeat (2) @(negedge clk);
    frame_active = 1'b1;
    @(negedge clk);
    @(negedge clk);
    frame_active = 1'b0;
    #3;
    check(!sck_tick && !lead_edge, "R9 strobe suppressed", {sck_tick, lead_edge}, 0);
    @(negedge clk);
    #3;
    check(sck == 1'b0, "R9 sck at idle", sck, 0);
    repeat (3) @(negedge clk);
    summary();
  end

endmodule